// File: doc/BRIEF.md
# Byte-wide host mailbox port with MPU-style register split

This block is the slave side of an 8-bit asynchronous host bus. A host CPU uses it to exchange bytes with an on-chip control processor. One address bit splits the port in two. With the bit low, the host reaches a data window: a write queues a byte toward the core and a read takes a byte from the core. With the bit high, a read returns a status byte and a write issues a control command. The host signals are an active-low chip select, active-low read and write strobes, a byte bus with an output-enable for the pad, and a tri-stateable active-high interrupt.

Each direction has a small FIFO. Host strobes are qualified by chip select and pass through a two-flop synchroniser. All actions happen on the synchronised release of a strobe, which is the host's rising edge. A state machine performs those actions. Its states are S_IDLE, S_PUSH, S_CMD, S_FLUSH, S_ACK and S_POP, and its transitions are:

- S_IDLE to S_PUSH on a data write release.
- S_IDLE to S_CMD on a control write release.
- S_IDLE to S_POP on a data read release.
- S_CMD to S_FLUSH for command 0xFF.
- S_CMD to S_IDLE for any other command.
- S_FLUSH to S_ACK.
- S_PUSH, S_POP and S_ACK back to S_IDLE.

Read data is driven combinationally from the raw strobes, so it is valid soon after the read strobe falls. Host accesses must be spaced at least 128 core clocks apart.

Top module: `mpu_host_port`

## Requirements
- R1: A status read (address bit high) drives bit 6 low exactly when the core-to-host FIFO holds a byte. Bits 5..0 always read 1.
- R2: Status bit 7 reads low while the host-to-core FIFO (depth 4) has room. It reads high once 4 bytes are queued.
- R3: Host data writes (address bit low) reach the core outputs in the order they were written.
- R4: A host data write while the host-to-core FIFO is full has no effect; the queued bytes are unchanged.
- R5: A host data read returns the oldest core byte, and that byte is removed after the read strobe is released.
- R6: The bus output enable is high only while chip select and read strobe are both low.
- R7: Control write 0xFF empties both FIFOs and then queues exactly one byte, 0xFE, for the host.
- R8: A control write of any value other than 0xFF leaves both FIFOs unchanged.
- R9: The interrupt output enable follows the core's interrupt enable. The interrupt is high only while it is enabled and the core-to-host FIFO is non-empty.
- R10: The handling of each host access completes within 128 core clocks of the strobe release.
- R11: The core push ready signal is low while the core-to-host FIFO holds 4 bytes, and a push then is ignored.
- R12: A data read with the core-to-host FIFO empty returns 0xFF and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Register select: 0 data, 1 status/control |
| host_d_in | input | 8 | Byte bus from host |
| host_d_out | output | 8 | Byte bus to host |
| host_d_oe | output | 1 | Byte bus pad output enable |
| host_irq | output | 1 | Interrupt, active high |
| host_irq_oe | output | 1 | Interrupt pad output enable |
| core_irq_en | input | 1 | Interrupt enable from core |
| core_rx_valid | output | 1 | Host-to-core byte available |
| core_rx_data | output | 8 | Oldest host-to-core byte |
| core_rx_pop | input | 1 | Core removes one host byte |
| core_tx_valid | input | 1 | Core pushes a byte to host |
| core_tx_data | input | 8 | Byte from core |
| core_tx_ready | output | 1 | Core-to-host FIFO accepts a push |

## Verification
The hardest situation to reach is a reset command arriving while both FIFOs are partly full. From the ports, the only evidence is what the core and host can still drain afterwards. The bench first loads bytes from both sides and then issues the command. It then shows that the core sees nothing, the host reads 0xFE, and the host's next read returns the empty value. Fill-level sweeps from zero to one past the depth in each direction reach the full and overflow corners.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_CMD,
        S_FLUSH,
        S_ACK,
        S_POP
    } port_state_t;

    localparam logic [7:0] CMD_RESET  = 8'hFF;
    localparam logic [7:0] RESET_ACK  = 8'hFE;
    localparam logic [7:0] EMPTY_READ = 8'hFF;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic act_o,
    output logic rel_o
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], async_i};
    end

    assign act_o = pipe_q[STAGES-1];
    assign rel_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             push_ok, pop_ok;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push & ~full & ~flush;
    assign pop_ok  = pop & ~empty & ~flush;
    assign dout    = mem_q[rptr_q];
    assign count   = cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wptr_q <= bump(wptr_q);
            if (pop_ok)  rptr_q <= bump(rptr_q);
            cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wptr_q] <= din;
    end
endmodule

// File: rtl/mpu_host_port.sv
module mpu_host_port
    import mpu_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_cs_n,
    input  logic       host_rd_n,
    input  logic       host_wr_n,
    input  logic       host_a0,
    input  logic [7:0] host_d_in,
    output logic [7:0] host_d_out,
    output logic       host_d_oe,
    output logic       host_irq,
    output logic       host_irq_oe,
    input  logic       core_irq_en,
    output logic       core_rx_valid,
    output logic [7:0] core_rx_data,
    input  logic       core_rx_pop,
    input  logic       core_tx_valid,
    input  logic [7:0] core_tx_data,
    output logic       core_tx_ready
);
    port_state_t state_q, state_d;

    logic wr_raw, rd_raw, wr_act, wr_rel, rd_act, rd_rel;
    logic wr_a0_q, rd_a0_q;
    logic [7:0] wr_byte_q;

    logic rx_push, tx_pop, flush, ack_push;
    logic tx_push;
    logic [7:0] tx_din, tx_head;
    logic [CNT_W-1:0] rx_count, tx_count;
    logic rx_full, rx_empty, tx_full, tx_empty;
    logic [7:0] status;

    assign wr_raw = ~host_cs_n & ~host_wr_n;
    assign rd_raw = ~host_cs_n & ~host_rd_n;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .async_i(wr_raw), .act_o(wr_act), .rel_o(wr_rel)
    );
    strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rd_raw), .act_o(rd_act), .rel_o(rd_rel)
    );

    // Address and data are sampled while the synchronised strobe is active;
    // the last sample before release is what the FSM acts on.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_a0_q   <= 1'b0;
            rd_a0_q   <= 1'b0;
            wr_byte_q <= '0;
        end else begin
            if (wr_act) begin
                wr_a0_q   <= host_a0;
                wr_byte_q <= host_d_in;
            end
            if (rd_act) rd_a0_q <= host_a0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and action strobes
    always_comb begin
        state_d  = state_q;
        rx_push  = 1'b0;
        tx_pop   = 1'b0;
        flush    = 1'b0;
        ack_push = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (wr_rel)                state_d = wr_a0_q ? S_CMD : S_PUSH;
                else if (rd_rel && !rd_a0_q) state_d = S_POP;
            end
            S_PUSH: begin
                rx_push = 1'b1;
                state_d = S_IDLE;
            end
            S_CMD: begin
                state_d = (wr_byte_q == CMD_RESET) ? S_FLUSH : S_IDLE;
            end
            S_FLUSH: begin
                flush   = 1'b1;
                state_d = S_ACK;
            end
            S_ACK: begin
                ack_push = 1'b1;
                state_d  = S_IDLE;
            end
            S_POP: begin
                tx_pop  = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .din(wr_byte_q),
        .pop(core_rx_pop), .dout(core_rx_data),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    assign core_tx_ready = ~tx_full & (state_q != S_FLUSH) & (state_q != S_ACK);
    assign tx_push       = ack_push | (core_tx_valid & core_tx_ready);
    assign tx_din        = ack_push ? RESET_ACK : core_tx_data;

    byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(tx_push), .din(tx_din),
        .pop(tx_pop), .dout(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    assign status        = {rx_full, ~tx_empty ? 1'b0 : 1'b1, 6'h3F};
    assign host_d_out    = host_a0 ? status : (tx_empty ? EMPTY_READ : tx_head);
    assign host_d_oe     = rd_raw;
    assign core_rx_valid = ~rx_empty;
    assign host_irq_oe   = core_irq_en;
    assign host_irq      = core_irq_en & ~tx_empty;
endmodule

// File: rtl/mpu_host_port_chk.sv
module mpu_host_port_chk
    import mpu_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int WR_WINDOW = 128,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int WIN_W = $clog2(WR_WINDOW + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input port_state_t      state_q,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             host_cs_n,
    input logic             host_rd_n,
    input logic             host_a0,
    input logic [7:0]       host_d_out,
    input logic             host_d_oe,
    input logic             host_irq,
    input logic             host_irq_oe,
    input logic             core_tx_ready
);
    logic [WIN_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                busy_cnt <= '0;
        else if (state_q == S_IDLE) busy_cnt <= '0;
        else if (busy_cnt != '1)   busy_cnt <= busy_cnt + 1'b1;
    end

    assert_status_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_d_oe && host_a0) |-> (host_d_out[5:0] == 6'h3F));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CNT_W'(DEPTH)) && (tx_count <= CNT_W'(DEPTH)));

    assert_oe_needs_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_d_oe |-> (!host_cs_n && !host_rd_n));

    assert_flush_then_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACK) |=> (tx_count == CNT_W'(1) && rx_count == '0));

    assert_irq_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (host_irq_oe && tx_count != '0));

    assert_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt < WIN_W'(WR_WINDOW));

    assert_tx_full_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == CNT_W'(DEPTH)) |-> !core_tx_ready);
endmodule

bind mpu_host_port mpu_host_port_chk #(.DEPTH(FIFO_DEPTH), .WR_WINDOW(128)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q),
    .rx_count(rx_count), .tx_count(tx_count),
    .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_a0(host_a0),
    .host_d_out(host_d_out), .host_d_oe(host_d_oe),
    .host_irq(host_irq), .host_irq_oe(host_irq_oe),
    .core_tx_ready(core_tx_ready)
);

// File: tb/mpu_host_port_tb.sv
module mpu_host_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_a0 = 1'b0;
    logic [7:0] host_d_in = '0;
    logic [7:0] host_d_out;
    logic host_d_oe, host_irq, host_irq_oe;
    logic core_irq_en = 1'b1;
    logic core_rx_valid;
    logic [7:0] core_rx_data;
    logic core_rx_pop = 1'b0;
    logic core_tx_valid = 1'b0;
    logic [7:0] core_tx_data = '0;
    logic core_tx_ready;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_host_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_a0(host_a0), .host_d_in(host_d_in),
        .host_d_out(host_d_out), .host_d_oe(host_d_oe),
        .host_irq(host_irq), .host_irq_oe(host_irq_oe),
        .core_irq_en(core_irq_en),
        .core_rx_valid(core_rx_valid), .core_rx_data(core_rx_data),
        .core_rx_pop(core_rx_pop),
        .core_tx_valid(core_tx_valid), .core_tx_data(core_tx_data),
        .core_tx_ready(core_tx_ready)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input int tx_n, input int rx_n);
        return {(rx_n >= DEPTH) ? 1'b1 : 1'b0, (tx_n == 0) ? 1'b1 : 1'b0, 6'h3F};
    endfunction

    task automatic host_write(input logic a0, input logic [7:0] d);
        @(negedge clk);
        host_a0 = a0; host_d_in = d; host_cs_n = 1'b0; host_wr_n = 1'b0;
        #1;
        check("R6 no drive on write", {7'd0, host_d_oe}, 8'd0);
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1; host_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic host_read(input logic a0, output logic [7:0] d, output logic oe);
        @(negedge clk);
        host_a0 = a0; host_cs_n = 1'b0; host_rd_n = 1'b0;
        #1;
        d = host_d_out; oe = host_d_oe;
        repeat (4) @(negedge clk);
        host_rd_n = 1'b1; host_cs_n = 1'b1;
        #1;
        check("R6 released after read", {7'd0, host_d_oe}, 8'd0);
        repeat (8) @(negedge clk);
    endtask

    task automatic core_push(input logic [7:0] d);
        @(negedge clk);
        core_tx_valid = 1'b1; core_tx_data = d;
        @(negedge clk);
        core_tx_valid = 1'b0;
    endtask

    task automatic core_take(output logic v, output logic [7:0] d);
        @(negedge clk);
        v = core_rx_valid; d = core_rx_data;
        core_rx_pop = 1'b1;
        @(negedge clk);
        core_rx_pop = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic oe, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Reset state
        check("R9 irq after reset", {7'd0, host_irq}, 8'd0);
        check("R3 rx empty after reset", {7'd0, core_rx_valid}, 8'd0);
        check("R6 idle bus", {7'd0, host_d_oe}, 8'd0);
        host_read(1'b1, d, oe);
        check("R1 R2 reset status", d, exp_status(0, 0));
        check("R6 drive on read", {7'd0, oe}, 8'd1);

        // Core-to-host sweep over fill level
        for (int k = 0; k <= DEPTH; k++) begin
            for (int i = 0; i < k; i++) core_push(8'(8'h40 + 16 * k + i));
            @(negedge clk);
            check("R11 ready vs fill", {7'd0, core_tx_ready}, {7'd0, k < DEPTH});
            check("R9 irq vs fill", {7'd0, host_irq}, {7'd0, k > 0});
            core_push(8'hEE);
            host_read(1'b1, d, oe);
            check("R1 status vs fill", d, exp_status((k < DEPTH) ? k + 1 : k, 0));
            for (int i = 0; i < k; i++) begin
                host_read(1'b0, d, oe);
                check("R5 ordered read", d, 8'(8'h40 + 16 * k + i));
            end
            if (k < DEPTH) begin
                host_read(1'b0, d, oe);
                check("R5 extra byte", d, 8'hEE);
            end
            host_read(1'b0, d, oe);
            check("R12 empty read", d, 8'hFF);
            host_read(1'b0, d, oe);
            check("R12 empty read twice", d, 8'hFF);
            host_read(1'b1, d, oe);
            check("R1 status drained", d, exp_status(0, 0));
        end

        // Host-to-core sweep over write count
        for (int n = 0; n <= DEPTH + 1; n++) begin
            for (int i = 0; i < n; i++) host_write(1'b0, 8'(8'h10 * i + n));
            host_read(1'b1, d, oe);
            check("R2 status vs writes", d, exp_status(0, n));
            for (int i = 0; i < ((n < DEPTH) ? n : DEPTH); i++) begin
                core_take(v, d);
                check("R3 rx valid", {7'd0, v}, 8'd1);
                check("R3 R4 rx order", d, 8'(8'h10 * i + n));
            end
            @(negedge clk);
            check("R4 nothing beyond depth", {7'd0, core_rx_valid}, 8'd0);
        end

        // Window after a write
        begin
            int cyc = 0;
            host_wr_n = 1'b1;
            @(negedge clk);
            host_a0 = 1'b0; host_d_in = 8'h5A; host_cs_n = 1'b0; host_wr_n = 1'b0;
            repeat (4) @(negedge clk);
            host_wr_n = 1'b1; host_cs_n = 1'b1;
            while (!core_rx_valid && cyc < 200) begin
                @(negedge clk);
                cyc++;
            end
            check("R10 handled in window", {7'd0, cyc < 128}, 8'd1);
            core_take(v, d);
            check("R10 byte", d, 8'h5A);
        end

        // Non-reset command
        host_write(1'b0, 8'hA1); host_write(1'b0, 8'hA2);
        core_push(8'hB1); core_push(8'hB2);
        host_write(1'b1, 8'h33);
        host_read(1'b1, d, oe);
        check("R8 status kept", d, exp_status(2, 2));
        core_take(v, d); check("R8 rx kept 1", d, 8'hA1);
        core_take(v, d); check("R8 rx kept 2", d, 8'hA2);
        host_read(1'b0, d, oe); check("R8 tx kept 1", d, 8'hB1);
        host_read(1'b0, d, oe); check("R8 tx kept 2", d, 8'hB2);

        // Reset command
        host_write(1'b0, 8'hC1); host_write(1'b0, 8'hC2);
        core_push(8'hD1); core_push(8'hD2);
        host_write(1'b1, 8'hFF);
        check("R7 rx flushed", {7'd0, core_rx_valid}, 8'd0);
        host_read(1'b1, d, oe);
        check("R7 status after flush", d, exp_status(1, 0));
        host_read(1'b0, d, oe); check("R7 ack byte", d, 8'hFE);
        host_read(1'b0, d, oe); check("R7 only ack", d, 8'hFF);

        // Interrupt enable
        core_push(8'h77);
        core_irq_en = 1'b0;
        @(negedge clk);
        check("R9 irq oe off", {7'd0, host_irq_oe}, 8'd0);
        check("R9 irq off", {7'd0, host_irq}, 8'd0);
        core_irq_en = 1'b1;
        @(negedge clk);
        check("R9 irq on", {6'd0, host_irq_oe, host_irq}, 8'd3);
        host_read(1'b0, d, oe);
        check("R5 irq byte", d, 8'h77);
        check("R9 irq clears", {7'd0, host_irq}, 8'd0);

        // Read strobe without select
        @(negedge clk);
        host_rd_n = 1'b0;
        #1;
        check("R6 no select no drive", {7'd0, host_d_oe}, 8'd0);
        host_rd_n = 1'b1;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule